// File: doc/BRIEF.md
# Chainable 16-bit Serial Register Slave

This block is a serial-peripheral slave that lets a host controller write a bank of six 13-bit control registers and read one 16-bit status word in the same transfer. Each word is 16 bits long and travels most significant bit first. Its top three bits pick the target register and its low thirteen bits carry the value. The chip select, serial clock and serial data input pins are oversampled by the system clock. Every transfer is rebuilt from the edges found in the system clock domain.

While chip select is low, the block shifts the status word out first. After that it replays the bits it has received, sixteen clocks later, so that several devices can be wired in a chain and share one select. When chip select is released, the last complete word received is committed. This happens only when the number of serial clocks in the frame is a non-zero multiple of sixteen. The addressed register takes the new value and its write strobe pulses for one system clock. Frames of any other length, and words addressed to the two unmapped codes, leave every register untouched.

Top module: `spi_chain_slave`

## Requirements
- R1: `sdo_oe` is 0 whenever `cs_n` is high and 1 whenever `cs_n` is low, so the data output is released outside a transfer.
- R2: The status word present at the first rising serial clock edge of a frame is shifted out on `sdo` over the first 16 clocks, bit 15 first, with one new bit after each rising edge.
- R3: From the 17th rising edge of a frame onward, `sdo` carries the bits received on `sdi` in the same frame, delayed by exactly 16 clocks and in arrival order.
- R4: `sdi` is sampled on each falling serial clock edge while `cs_n` is low. The last 16 bits received form the word: bits 15..13 are the register address and bits 12..0 are the register value.
- R5: A frame with fewer than 16 serial clock edges writes no register and pulses no strobe.
- R6: A frame whose clock count is 16 or more but not a multiple of 16 writes no register and pulses no strobe.
- R7: When `cs_n` rises after a frame of 16·k clocks (k ≥ 1), the register whose index equals the address field (0 to 5) takes the value field. Its strobe pulses high for exactly one system clock, and no other register or strobe changes.
- R8: A valid frame that carries address 6 or 7 writes no register and pulses no strobe.
- R9: After reset, every control register reads zero and every strobe is low.
- R10: Serial clock edges that occur while `cs_n` is high cause no register write and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on falling serial clock edges |
| sdo | output | 1 | Serial data out, changes after rising serial clock edges |
| sdo_oe | output | 1 | Output enable for the tri-state buffer of `sdo` |
| status_in | input | 16 | Status word loaded at the first rising edge of a frame |
| ctrl_q | output | 6×13 | Control registers, index equals address |
| ctrl_we | output | 6 | One-cycle write strobe per control register |

## Verification
The assertions assume that the three serial pins change slowly compared with the system clock. Each level must last at least four system clocks, a chip select edge must never land in the same synchronized cycle as a serial clock edge, and `status_in` must be steady around the first rising edge. The bench drives every serial level for four system clocks and keeps chip select settled for several clocks on both sides of each frame, so those assumptions always hold. It sweeps every address with valid frames, every frame length from 1 to 48 clocks, and serial clock activity with chip select high. For each of these it computes the expected output stream and register contents arithmetically.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

   // Synchronized view of one serial pin as seen in the system clock domain.
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } pin_evt_t;

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync
   import spi_chain_pkg::*;
#(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pin,
   output pin_evt_t evt
);

   localparam int CHAIN_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_chain_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value.
   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {CHAIN_W{RST_VAL}};
      end else begin
         chain <= {chain[CHAIN_W-2:0], pin};
      end
   end

   always_comb begin
      evt.level = chain[STAGES-1];
      evt.rise  = chain[STAGES-1] & ~chain[STAGES];
      evt.fall  = ~chain[STAGES-1] & chain[STAGES];
   end

endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter
   import spi_chain_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pin_evt_t          cs_evt,
   input  pin_evt_t          sclk_evt,
   input  pin_evt_t          sdi_evt,
   input  logic [WORD_W-1:0] status_in,
   output logic              sdo_bit,
   output logic              first_pend,
   output logic              commit,
   output logic [WORD_W-1:0] word
);

   localparam int CNT_W = $clog2(WORD_W);

   if (WORD_W < 4 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("spi_chain_shifter: WORD_W must be a power of two of at least 4");
   end

   logic              active;
   logic [WORD_W-1:0] in_sr;
   logic [WORD_W-1:0] out_sr;
   logic [CNT_W-1:0]  bit_cnt;
   logic              full_seen;

   assign active  = ~cs_evt.level;
   assign sdo_bit = out_sr[WORD_W-1];
   assign word    = in_sr;

   // Output side: preload status at the first rise, then act as a delay line.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sr     <= '0;
         first_pend <= 1'b0;
      end else if (cs_evt.fall) begin
         first_pend <= 1'b1;
      end else if (active && sclk_evt.rise) begin
         first_pend <= 1'b0;
         if (first_pend) begin
            out_sr <= status_in;
         end else begin
            out_sr <= {out_sr[WORD_W-2:0], in_sr[0]};
         end
      end
   end

   // Input side: capture on falling edges, count modulo the word length.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_sr     <= '0;
         bit_cnt   <= '0;
         full_seen <= 1'b0;
      end else if (cs_evt.fall) begin
         bit_cnt   <= '0;
         full_seen <= 1'b0;
      end else if (active && sclk_evt.fall) begin
         in_sr   <= {in_sr[WORD_W-2:0], sdi_evt.level};
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == CNT_W'(WORD_W - 1)) begin
            full_seen <= 1'b1;
         end
      end
   end

   // Commit on deselect only when the frame held a whole number of words.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit <= 1'b0;
      end else begin
         commit <= cs_evt.rise && full_seen && (bit_cnt == '0);
      end
   end

endmodule

// File: rtl/spi_chain_regbank.sv
module spi_chain_regbank #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 3,
   parameter int NREG   = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  logic [WORD_W-1:0]            word,
   output logic [NREG-1:0][WORD_W-ADDR_W-1:0] ctrl_q,
   output logic [NREG-1:0]              ctrl_we
);

   localparam int DATA_W = WORD_W - ADDR_W;

   if (NREG < 1 || NREG > (1 << ADDR_W)) begin : g_bad_nreg
      $error("spi_chain_regbank: NREG must fit the address field");
   end

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;

   assign addr = word[WORD_W-1 -: ADDR_W];
   assign data = word[DATA_W-1:0];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit;
      assign hit = commit && (addr == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[i]  <= '0;
            ctrl_we[i] <= 1'b0;
         end else begin
            ctrl_we[i] <= hit;
            if (hit) begin
               ctrl_q[i] <= data;
            end
         end
      end
   end

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
   import spi_chain_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int NREG        = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cs_n,
   input  logic                                sclk,
   input  logic                                sdi,
   output logic                                sdo,
   output logic                                sdo_oe,
   input  logic [WORD_W-1:0]                   status_in,
   output logic [NREG-1:0][WORD_W-ADDR_W-1:0]  ctrl_q,
   output logic [NREG-1:0]                     ctrl_we
);

   localparam int NPIN = 3;
   localparam logic [NPIN-1:0] PIN_RST = 3'b100; // cs idles high

   if (ADDR_W >= WORD_W) begin : g_bad_addr
      $error("spi_chain_slave: ADDR_W must be smaller than WORD_W");
   end

   logic     [NPIN-1:0] pins;
   pin_evt_t            evts [NPIN];

   assign pins = {cs_n, sclk, sdi};

   for (genvar p = 0; p < NPIN; p++) begin : g_sync
      spi_chain_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (PIN_RST[p])
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (pins[p]),
         .evt   (evts[p])
      );
   end

   logic              cs_lvl;
   logic              sclk_rise;
   logic              first_pend;
   logic              commit;
   logic [WORD_W-1:0] word;

   assign cs_lvl    = evts[2].level;
   assign sclk_rise = evts[1].rise;

   spi_chain_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_evt     (evts[2]),
      .sclk_evt   (evts[1]),
      .sdi_evt    (evts[0]),
      .status_in  (status_in),
      .sdo_bit    (sdo),
      .first_pend (first_pend),
      .commit     (commit),
      .word       (word)
   );

   spi_chain_regbank #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .NREG   (NREG)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .word    (word),
      .ctrl_q  (ctrl_q),
      .ctrl_we (ctrl_we)
   );

   // Output is driven only while the pin-level select is active.
   assign sdo_oe = ~cs_n;

endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 3,
   parameter int NREG   = 6
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               cs_lvl,
   input logic                               sclk_rise,
   input logic                               first_pend,
   input logic                               commit,
   input logic                               sdo,
   input logic [WORD_W-1:0]                  status_in,
   input logic [NREG-1:0][WORD_W-ADDR_W-1:0] ctrl_q,
   input logic [NREG-1:0]                    ctrl_we
);

   // R7: at most one strobe at a time
   a_r7_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_we));

   // R7: a strobe lasts exactly one system clock
   a_r7_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (|ctrl_we) |=> !(|ctrl_we));

   // R5, R6, R10: registers change only together with a strobe
   a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ctrl_we) |-> $stable(ctrl_q));

   // R5: a commit never happens while the frame is still open
   a_r5_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> cs_lvl);

   // R2: the first rising edge presents the status MSB
   a_r2_status_preload: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && first_pend && !cs_lvl) |=> (sdo == $past(status_in[WORD_W-1])));

endmodule

bind spi_chain_slave spi_chain_slave_chk #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W),
   .NREG   (NREG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_lvl     (cs_lvl),
   .sclk_rise  (sclk_rise),
   .first_pend (first_pend),
   .commit     (commit),
   .sdo        (sdo),
   .status_in  (status_in),
   .ctrl_q     (ctrl_q),
   .ctrl_we    (ctrl_we)
);

// File: tb/spi_chain_slave_test.sv
module spi_chain_slave_test;

   localparam int NREG = 6;
   localparam int DW   = 13;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic sdo;
   logic sdo_oe;
   logic [15:0] status_in = '0;
   logic [NREG-1:0][DW-1:0] ctrl_q;
   logic [NREG-1:0] ctrl_we;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [DW-1:0] model_q [NREG];
   int exp_pulses [NREG];
   int pulses [NREG];
   int high_cycles [NREG];
   logic [NREG-1:0] we_prev = '0;

   always #10 clk = ~clk;

   spi_chain_slave uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe),
      .status_in (status_in),
      .ctrl_q    (ctrl_q),
      .ctrl_we   (ctrl_we)
   );

   // Strobe monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            if (ctrl_we[i]) high_cycles[i]++;
            if (ctrl_we[i] && !we_prev[i]) pulses[i]++;
         end
      end
      we_prev <= ctrl_we;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_bank(input string req);
      bit ok = 1'b1;
      int bad = -1;
      for (int i = 0; i < NREG; i++) begin
         if (ctrl_q[i] !== model_q[i] || pulses[i] != exp_pulses[i] ||
             high_cycles[i] != exp_pulses[i]) begin
            ok = 1'b0;
            if (bad < 0) bad = i;
         end
      end
      if (bad < 0) bad = 0;
      check(ok, req, $sformatf("reg%0d value/pulses/high", bad),
            {ctrl_q[bad], 8'(pulses[bad]), 8'(high_cycles[bad])},
            {model_q[bad], 8'(exp_pulses[bad]), 8'(exp_pulses[bad])});
   endtask

   // One frame of nbits clocks; bits sent MSB first from bits[nbits-1].
   task automatic frame(input int nbits, input logic [47:0] bits,
                        input logic [15:0] status, input string req);
      bit sdo_ok = 1'b1;
      int bad_k = 0;
      logic exp_b = 1'b0;
      logic act_b = 1'b0;
      logic [15:0] w;
      status_in = status;
      cs_n = 1'b0;
      tick(HALF);
      check(sdo_oe === 1'b1, "R1", "oe while selected", sdo_oe, 1);
      for (int k = 0; k < nbits; k++) begin
         sdi  = bits[nbits-1-k];
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
         tick(HALF);
         if (k < 16) exp_b = status[15-k];
         else        exp_b = bits[nbits-1-(k-16)];
         if (sdo !== exp_b && sdo_ok) begin
            sdo_ok = 1'b0;
            bad_k = k;
            act_b = sdo;
         end
      end
      if (nbits > 0) begin
         check(sdo_ok, (nbits > 16) ? "R3" : "R2",
               $sformatf("%s sdo bit %0d of %0d", req, bad_k, nbits), act_b,
               (bad_k < 16) ? status[15-bad_k] : bits[nbits-1-(bad_k-16)]);
      end
      cs_n = 1'b1;
      tick(10);
      check(sdo_oe === 1'b0, "R1", "oe while idle", sdo_oe, 0);
      if (nbits >= 16 && nbits % 16 == 0) begin
         w = bits[15:0];
         if (w[15:13] < NREG) begin
            model_q[w[15:13]] = w[12:0];
            exp_pulses[w[15:13]]++;
         end
      end
      check_bank(req);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NREG; i++) begin
         model_q[i] = '0;
         exp_pulses[i] = 0;
         pulses[i] = 0;
         high_cycles[i] = 0;
      end
      tick(4);
      rst_n = 1'b1;
      tick(4);
      // R9: reset state
      check_bank("R9");
      check(ctrl_we === '0, "R9", "strobes after reset", ctrl_we, 0);
      check(sdo_oe === 1'b0, "R1", "oe after reset", sdo_oe, 0);

      // R7, R8, R4: one valid frame per address code
      for (int a = 0; a < 8; a++) begin
         logic [12:0] d = 13'((a * 1237 + 341) ^ 13'h0A5A);
         frame(16, {32'h0, 3'(a), d}, 16'h8000 | 16'(a * 16'h1357),
               (a < NREG) ? "R7" : "R8");
      end

      // R5, R6: every length from 1 to 48, valid lengths too
      for (int n = 1; n <= 48; n++) begin
         logic [47:0] b = 48'(64'h9E3779B97F4A * 64'(n + 3));
         frame(n, b, 16'(16'hC3A5 ^ (n * 16'h0F1D)),
               (n < 16) ? "R5" : ((n % 16 != 0) ? "R6" : "R7"));
      end

      // R3, R4: chained frames, last word lands in a mapped register
      frame(32, {16'h0, 16'hFFFF, 3'd2, 13'h1ABC}, 16'h0001, "R3");
      frame(48, {3'd5, 13'h0F0F, 3'd7, 13'h1111, 3'd1, 13'h1555}, 16'h7FFE, "R4");

      // R10: serial clock activity with chip select high
      for (int k = 0; k < 40; k++) begin
         sdi  = k[0];
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
         tick(HALF);
      end
      tick(8);
      check_bank("R10");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule